// File: doc/BRIEF.md
# Light and Proximity Measurement Sequencer

This block sequences the measurements of a combined ambient-light and proximity sensor. A master enable in the control register wakes it from sleep. It then cycles through a start step, a proximity step, a pause step and a light step, and repeats this cycle for as long as the enable stays set. Each of the three working steps has its own enable bit. A disabled step is crossed in a single cycle with no action.

The converters are outside the block. The block sees them only as handshakes. A proximity conversion is a one-cycle request answered by a done pulse. A light conversion first integrates both channels together, with a run level held for a programmed number of base ticks, and then waits for a done pulse that carries both 16-bit channel counts. The two counts are staged and then copied together into readable registers. Reading a low byte stores the matching high byte, so a split two-byte read always returns one sample.

When the master enable is cleared, the step in progress runs to its end, including any conversion, and the sequencer then goes straight to sleep.

Top module: `lps_seq`

## Requirements
- R1: During and after synchronous reset, `phase` is 0 (sleep), `prox_start`, `als_run` and `als_gain` are 0, and every register reads 0.
- R2: `phase` encodes 0 sleep, 1 start, 2 proximity, 3 pause, 4 light. In the cycle after a write sets bit 0 of address 0x00, the sequencer leaves sleep for start. While that bit is 0, the sequencer stays in sleep.
- R3: While bit 0 stays set, the phases follow start, proximity, pause, light and then start again, with no other order.
- R4: The enable bits at address 0x00 are bit 1 for light, bit 2 for proximity and bit 3 for pause. A step whose bit is 0 lasts exactly one cycle, with no `prox_start` and no `als_run`.
- R5: After bit 0 is cleared, the step in progress completes, including its conversion and the capture of its result. The next phase is then sleep, with no further step.
- R6: An enabled proximity step raises `prox_start` for exactly its first cycle. It then holds until `prox_done`.
- R7: An enabled light step holds `als_run` for 256 minus the value at address 0x01, counted in `tick` cycles. It then waits for `als_done` and captures `als_ch0` and `als_ch1` in that same cycle.
- R8: An enabled pause step lasts 256 minus the value at address 0x03, counted in `tick` cycles.
- R9: Bits 1:0 of address 0x0F drive `als_gain`, with codes 0 to 3 standing for 1x, 8x, 16x and 120x. A read of 0x0F returns only these bits.
- R10: Channel 0 reads at 0x14 (low byte) and 0x15 (high byte). Channel 1 reads at 0x16 (low byte) and 0x17 (high byte). Both channels become visible in the same cycle, one cycle after capture.
- R11: A read of 0x14 or 0x16 stores the high byte of that channel. A read of 0x15 or 0x17 returns the stored byte, even if a newer sample has arrived since.
- R12: Address 0x00 reads back its four bits in bits 3:0. An address with no register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Base timing strobe for integration and pause counts |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (stores the high byte on a low-byte read) |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| phase | output | 3 | Current step code |
| prox_start | output | 1 | One-cycle proximity conversion request |
| prox_done | input | 1 | Proximity conversion finished |
| als_run | output | 1 | Both light channels integrating |
| als_gain | output | 2 | Light gain code |
| als_done | input | 1 | Light conversion finished, channel counts valid |
| als_ch0 | input | 16 | Visible plus infrared channel count |
| als_ch1 | input | 16 | Infrared channel count |

## Verification
The assertions check the legal phase successions on every cycle. They also check that sleep is entered only after the master enable has been cleared, that the proximity request is a single-cycle pulse, and that the two visible channel registers change only in the cycle after a staged capture. The bench's scenarios are needed for everything else. They cover the cycle length of each step under its programmed counts, the one-cycle crossing of disabled steps, how a power-down in the middle of a proximity or light conversion plays out, and that the stored high byte survives a newer sample.

// File: rtl/lps_pkg.sv
package lps_pkg;
    localparam int TIME_W = 8;
    localparam int CNT_W  = TIME_W + 1;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;
    localparam int BYTE_W = 8;

    localparam logic [ADDR_W-1:0] A_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] A_ITIME = 8'h01;
    localparam logic [ADDR_W-1:0] A_PTIME = 8'h03;
    localparam logic [ADDR_W-1:0] A_GAIN  = 8'h0F;
    localparam logic [ADDR_W-1:0] A_C0LO  = 8'h14;
    localparam logic [ADDR_W-1:0] A_C0HI  = 8'h15;
    localparam logic [ADDR_W-1:0] A_C1LO  = 8'h16;
    localparam logic [ADDR_W-1:0] A_C1HI  = 8'h17;

    typedef enum logic [2:0] {
        PH_SLEEP = 3'd0,
        PH_START = 3'd1,
        PH_PROX  = 3'd2,
        PH_PAUSE = 3'd3,
        PH_LIGHT = 3'd4
    } phase_e;

    typedef enum logic [2:0] {
        S_SLEEP, S_START, S_PROX_GO, S_PROX_HOLD, S_PAUSE, S_INTEG, S_CONV
    } seq_state_e;

    typedef struct packed {
        logic pause_en;
        logic prox_en;
        logic light_en;
        logic pon;
    } ctrl_t;

    typedef struct packed {
        logic [DATA_W-1:0] ch1;
        logic [DATA_W-1:0] ch0;
    } pair_t;

    function automatic logic [CNT_W-1:0] span_of(input logic [TIME_W-1:0] v);
        return {1'b1, {TIME_W{1'b0}}} - {1'b0, v};
    endfunction
endpackage

// File: rtl/lps_regs.sv
module lps_regs
    import lps_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic                rd,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [BYTE_W-1:0]   rdata,
    input  logic                cap_valid,
    input  pair_t               cap,
    output ctrl_t               ctrl,
    output logic [TIME_W-1:0]   itime,
    output logic [TIME_W-1:0]   ptime,
    output logic [1:0]          gain
);
    pair_t             stage_q;
    pair_t             vis_q;
    logic              pend_q;
    logic [BYTE_W-1:0] hold0_q;
    logic [BYTE_W-1:0] hold1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            itime   <= '0;
            ptime   <= '0;
            gain    <= '0;
            stage_q <= '0;
            vis_q   <= '0;
            pend_q  <= 1'b0;
            hold0_q <= '0;
            hold1_q <= '0;
        end else begin
            if (wr) begin
                case (addr)
                    A_CTRL:  ctrl  <= ctrl_t'(wdata[3:0]);
                    A_ITIME: itime <= wdata;
                    A_PTIME: ptime <= wdata;
                    A_GAIN:  gain  <= wdata[1:0];
                    default: ;
                endcase
            end
            if (cap_valid) stage_q <= cap;
            if (pend_q)    vis_q   <= stage_q;
            pend_q <= cap_valid;
            if (rd && addr == A_C0LO) hold0_q <= vis_q.ch0[DATA_W-1:BYTE_W];
            if (rd && addr == A_C1LO) hold1_q <= vis_q.ch1[DATA_W-1:BYTE_W];
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = {4'b0, ctrl};
            A_ITIME: rdata = itime;
            A_PTIME: rdata = ptime;
            A_GAIN:  rdata = {6'b0, gain};
            A_C0LO:  rdata = vis_q.ch0[BYTE_W-1:0];
            A_C0HI:  rdata = hold0_q;
            A_C1LO:  rdata = vis_q.ch1[BYTE_W-1:0];
            A_C1HI:  rdata = hold1_q;
            default: rdata = '0;
        endcase
    end

    // R10: the visible pair moves only as a whole, one cycle after a capture
    a_r10_pair_from_stage: assert property (@(posedge clk) disable iff (rst)
        !$stable(vis_q) |-> $past(pend_q));
endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
    import lps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  ctrl_t             ctrl,
    input  logic [TIME_W-1:0] itime,
    input  logic [TIME_W-1:0] ptime,
    input  logic              prox_done,
    input  logic              als_done,
    input  logic [DATA_W-1:0] als_ch0,
    input  logic [DATA_W-1:0] als_ch1,
    output phase_e            phase,
    output logic              prox_start,
    output logic              als_run,
    output logic              cap_valid,
    output pair_t             cap
);
    seq_state_e       state_q, nxt;
    logic [CNT_W-1:0] cnt_q;
    logic             last_tick;
    logic             rst_d;

    assign last_tick = tick && (cnt_q == CNT_W'(1));

    always_comb begin
        nxt = state_q;
        case (state_q)
            S_SLEEP:     if (ctrl.pon) nxt = S_START;
            S_START:     nxt = ctrl.pon ? S_PROX_GO : S_SLEEP;
            S_PROX_GO:   if (ctrl.prox_en) nxt = S_PROX_HOLD;
                         else nxt = ctrl.pon ? S_PAUSE : S_SLEEP;
            S_PROX_HOLD: if (prox_done) nxt = ctrl.pon ? S_PAUSE : S_SLEEP;
            S_PAUSE:     if (!ctrl.pause_en || last_tick)
                             nxt = ctrl.pon ? S_INTEG : S_SLEEP;
            S_INTEG:     if (!ctrl.light_en) nxt = ctrl.pon ? S_START : S_SLEEP;
                         else if (last_tick) nxt = S_CONV;
            S_CONV:      if (als_done) nxt = ctrl.pon ? S_START : S_SLEEP;
            default:     nxt = S_SLEEP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_SLEEP;
            cnt_q   <= '0;
        end else begin
            state_q <= nxt;
            if (nxt == S_PAUSE && state_q != S_PAUSE)
                cnt_q <= span_of(ptime);
            else if (nxt == S_INTEG && state_q != S_INTEG)
                cnt_q <= span_of(itime);
            else if ((state_q == S_PAUSE || state_q == S_INTEG) && tick)
                cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    always_comb begin
        case (state_q)
            S_START:                phase = PH_START;
            S_PROX_GO, S_PROX_HOLD: phase = PH_PROX;
            S_PAUSE:                phase = PH_PAUSE;
            S_INTEG, S_CONV:        phase = PH_LIGHT;
            default:                phase = PH_SLEEP;
        endcase
    end

    assign prox_start = (state_q == S_PROX_GO) && ctrl.prox_en;
    assign als_run    = (state_q == S_INTEG) && ctrl.light_en;
    assign cap_valid  = (state_q == S_CONV) && als_done;
    assign cap.ch0    = als_ch0;
    assign cap.ch1    = als_ch1;

    always_ff @(posedge clk) rst_d <= rst;

    always_ff @(posedge clk) begin
        if (rst_d) begin
            a_r1_sleep_after_reset: assert (phase == PH_SLEEP);
        end
    end

    a_r3_start_then_prox: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_START) |=> (phase == PH_PROX || phase == PH_SLEEP));
    a_r3_prox_then_pause: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PROX) |=> (phase == PH_PROX || phase == PH_PAUSE || phase == PH_SLEEP));
    a_r3_pause_then_light: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PAUSE) |=> (phase == PH_PAUSE || phase == PH_LIGHT || phase == PH_SLEEP));
    a_r3_light_then_start: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LIGHT) |=> (phase == PH_LIGHT || phase == PH_START || phase == PH_SLEEP));
    a_r5_sleep_needs_off: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SLEEP && $past(phase) != PH_SLEEP) |-> !$past(ctrl.pon));
    a_r6_start_is_pulse: assert property (@(posedge clk) disable iff (rst)
        prox_start |=> !prox_start);
endmodule

// File: rtl/lps_seq.sv
module lps_seq
    import lps_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic [2:0]  phase,
    output logic        prox_start,
    input  logic        prox_done,
    output logic        als_run,
    output logic [1:0]  als_gain,
    input  logic        als_done,
    input  logic [15:0] als_ch0,
    input  logic [15:0] als_ch1
);
    ctrl_t             ctrl;
    logic [TIME_W-1:0] itime;
    logic [TIME_W-1:0] ptime;
    logic              cap_valid;
    pair_t             cap;
    phase_e            ph;

    lps_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .rd        (reg_rd),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .cap_valid (cap_valid),
        .cap       (cap),
        .ctrl      (ctrl),
        .itime     (itime),
        .ptime     (ptime),
        .gain      (als_gain)
    );

    lps_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .ctrl       (ctrl),
        .itime      (itime),
        .ptime      (ptime),
        .prox_done  (prox_done),
        .als_done   (als_done),
        .als_ch0    (als_ch0),
        .als_ch1    (als_ch1),
        .phase      (ph),
        .prox_start (prox_start),
        .als_run    (als_run),
        .cap_valid  (cap_valid),
        .cap        (cap)
    );

    assign phase = ph;
endmodule

// File: tb/lps_seq_test.sv
`timescale 1ns/1ps
module lps_seq_test;
    logic        clk = 0;
    logic        rst = 1;
    logic        tick = 1;
    logic        reg_wr = 0, reg_rd = 0;
    logic [7:0]  reg_addr = 0, reg_wdata = 0;
    logic [7:0]  reg_rdata;
    logic [2:0]  phase;
    logic        prox_start, prox_done = 0;
    logic        als_run, als_done = 0;
    logic [1:0]  als_gain;
    logic [15:0] ch0_src = 0, ch1_src = 0;

    int errors = 0, checks = 0;
    int exp_q[$];
    int n_start, n_run;
    int pcnt = 0, acnt = 0;
    logic run_seen = 0;

    always #10 clk = ~clk;

    lps_seq uut (
        .clk(clk), .rst(rst), .tick(tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .phase(phase), .prox_start(prox_start), .prox_done(prox_done),
        .als_run(als_run), .als_gain(als_gain), .als_done(als_done),
        .als_ch0(ch0_src), .als_ch1(ch1_src)
    );

    // converter models: done two cycles after the request or end of integration
    always @(negedge clk) begin
        prox_done = (pcnt == 1);
        if (pcnt > 0) pcnt--;
        if (prox_start === 1'b1) pcnt = 2;
        als_done = (acnt == 1);
        if (acnt > 0) acnt--;
        if (run_seen && als_run === 1'b0) acnt = 2;
        run_seen = (als_run === 1'b1);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        reg_rd = 1; reg_addr = a;
        #2;
        chk(reg_rdata === exp, req, reg_rdata, exp);
        @(negedge clk);
        reg_rd = 0;
    endtask

    // reference: expected step occupancy per cycle
    task automatic expect_phase(input int ph, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(ph);
    endtask

    task automatic trace(input string req);
        n_start = 0; n_run = 0;
        while (exp_q.size() > 0) begin
            int e;
            e = exp_q.pop_front();
            chk(phase === e[2:0], req, phase, e);
            if (prox_start === 1'b1) n_start++;
            if (als_run === 1'b1) n_run++;
            @(negedge clk);
        end
    endtask

    initial begin
        #4000000;
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(phase === 3'd0, "R1 phase", phase, 0);
        chk(prox_start === 0 && als_run === 0, "R1 strobes", {prox_start, als_run}, 0);
        chk(als_gain === 2'd0, "R1 gain", als_gain, 0);
        rst = 0;
        @(negedge clk);
        rd_chk(8'h00, 8'h00, "R1 ctrl");
        rd_chk(8'h14, 8'h00, "R1 ch0 lo");
        rd_chk(8'h17, 8'h00, "R1 ch1 hi");

        // R9: gain field
        wr(8'h0F, 8'hFF);
        chk(als_gain === 2'd3, "R9 gain out", als_gain, 3);
        rd_chk(8'h0F, 8'h03, "R9 gain readback");
        wr(8'h0F, 8'h02);
        chk(als_gain === 2'd2, "R9 gain out", als_gain, 2);
        rd_chk(8'h02, 8'h00, "R12 empty address");

        // R12 / R2: enables without power stay asleep
        wr(8'h00, 8'h0E);
        rd_chk(8'h00, 8'h0E, "R12 ctrl readback");
        repeat (3) @(negedge clk);
        chk(phase === 3'd0, "R2 no power stays sleep", phase, 0);

        // R2 R3 R4: power only, every step disabled
        wr(8'h00, 8'h01);
        expect_phase(0, 1); expect_phase(1, 1); expect_phase(2, 1); expect_phase(3, 1);
        expect_phase(4, 1); expect_phase(1, 1); expect_phase(2, 1); expect_phase(3, 1);
        trace("R3 disabled cycle");
        chk(n_start == 0 && n_run == 0, "R4 no action when disabled", n_start + n_run, 0);
        wr(8'h00, 8'h00);
        repeat (4) @(negedge clk);
        chk(phase === 3'd0, "R5 back to sleep", phase, 0);

        // R6 R7 R8: full cycle with programmed counts
        wr(8'h01, 8'hFE);
        wr(8'h03, 8'hFD);
        ch0_src = 16'h1234; ch1_src = 16'hABCD;
        wr(8'h00, 8'h0F);
        expect_phase(0, 1); expect_phase(1, 1); expect_phase(2, 3);
        expect_phase(3, 3); expect_phase(4, 5); expect_phase(1, 1);
        trace("R8 R7 full cycle");
        chk(n_start == 1, "R6 single request", n_start, 1);
        chk(n_run == 2, "R7 integration ticks", n_run, 2);

        // R10 R11: data map and stored high byte
        ch0_src = 16'h5678; ch1_src = 16'h0F1E;
        rd_chk(8'h14, 8'h34, "R10 ch0 lo");
        rd_chk(8'h16, 8'hCD, "R10 ch1 lo");
        repeat (20) @(negedge clk);
        rd_chk(8'h15, 8'h12, "R11 ch0 held hi");
        rd_chk(8'h17, 8'hAB, "R11 ch1 held hi");
        rd_chk(8'h14, 8'h78, "R10 ch0 new lo");
        rd_chk(8'h15, 8'h56, "R10 ch0 new hi");
        rd_chk(8'h16, 8'h1E, "R10 ch1 new lo");
        rd_chk(8'h17, 8'h0F, "R10 ch1 new hi");

        // R5: power cleared during proximity conversion
        while (prox_start !== 1'b1) @(negedge clk);
        reg_wr = 1; reg_addr = 8'h00; reg_wdata = 8'h0E;
        chk(phase === 3'd2, "R5 prox entry", phase, 2);
        @(negedge clk);
        reg_wr = 0;
        expect_phase(2, 2); expect_phase(0, 2);
        trace("R5 prox finishes then sleep");
        chk(n_start == 0, "R5 no new request", n_start, 0);

        // R5: power cleared during light integration
        wr(8'h00, 8'h0F);
        ch0_src = 16'hCAFE; ch1_src = 16'hBEEF;
        while (als_run !== 1'b1) @(negedge clk);
        reg_wr = 1; reg_addr = 8'h00; reg_wdata = 8'h0E;
        chk(phase === 3'd4, "R5 light entry", phase, 4);
        @(negedge clk);
        reg_wr = 0;
        expect_phase(4, 4); expect_phase(0, 2);
        trace("R5 light finishes then sleep");
        rd_chk(8'h14, 8'hFE, "R5 R10 capture completed");
        rd_chk(8'h15, 8'hCA, "R10 ch0 hi");
        rd_chk(8'h16, 8'hEF, "R10 ch1 lo");
        rd_chk(8'h17, 8'hBE, "R10 ch1 hi");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule